// File: doc/BRIEF.md
# Burst-of-Four Byte-Masked Memory

This block is a single-clock on-chip memory. It is organised around fixed bursts of four words. A write command carries one address. The four data words that follow, one per clock, land at that aligned address and at the three locations after it. Each word is 18 bits wide and is split into two 9-bit bytes.

Every byte has its own active-low write enable, sampled on the same edge as its data. Masking can therefore change from one beat to the next within a burst: any byte of any beat can be left untouched. A separate read port takes one address and returns the four words of the aligned block on consecutive cycles, each beat marked by a valid flag.

Both ports signal with a busy output while a burst is running. A command that arrives while its port is busy is dropped.

Top module: `burst4_sram`

## Requirements
- R1: The two least significant address bits of a write or read command are ignored. Every burst starts at the address with those bits cleared.
- R2: A write command sampled while `wr_busy_o` is low is accepted. The data words sampled on the next four rising edges are stored at base+0, base+1, base+2 and base+3, in that order.
- R3: Enable bit 0 of `wr_ben_ni` governs data bits 8:0 and enable bit 1 governs bits 17:9. Both are active low. A high enable on a beat leaves that byte of the addressed word unchanged.
- R4: Enables are sampled per beat, so each beat of a burst can mask a different set of bytes. For example: only the low byte on beat 0, only the high byte on beat 1, both bytes on beat 2, only the high byte on beat 3.
- R5: `wr_busy_o` rises after the edge that accepts a write command and stays high for exactly four cycles.
- R6: A write command sampled while `wr_busy_o` is high has no effect. Write data and enables sampled while no write burst runs change nothing.
- R7: After a read command is accepted on edge E0, the word at base+n appears on `rd_data_o` with `rd_valid_o` high after edge E(n+1), for n = 0..3.
- R8: `rd_busy_o` is high for exactly four cycles after an accepted read command. A read command sampled while `rd_busy_o` is high is ignored and produces no extra beats.
- R9: While `rst_ni` is low, and until the first command, `wr_busy_o`, `rd_busy_o` and `rd_valid_o` are low and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_cmd_i | input | 1 | Write command strobe |
| wr_addr_i | input | ADDR_W | Write base address (low two bits ignored) |
| wr_data_i | input | 18 | Write data beat |
| wr_ben_ni | input | 2 | Per-byte write enable, active low |
| wr_busy_o | output | 1 | Write burst in progress |
| rd_cmd_i | input | 1 | Read command strobe |
| rd_addr_i | input | ADDR_W | Read base address (low two bits ignored) |
| rd_data_o | output | 18 | Read data beat |
| rd_valid_o | output | 1 | Read beat valid |
| rd_busy_o | output | 1 | Read burst in progress |

## Verification
The assertions watch the burst framing on every cycle:
- an accepted command raises the matching busy flag;
- each busy run lasts exactly four cycles, so a command dropped mid-burst cannot restart or stretch it;
- byte write strobes only occur inside a write burst;
- every read-busy cycle is followed by a valid beat, and no valid beat appears without one.

The bench scenarios show what no property over the ports can see:
- that each byte of each beat reached the right aligned location, or stayed untouched when masked;
- that unaligned addresses fold onto the block start;
- that read data matches a reference model after randomised bursts with random per-beat masks.

// File: rtl/burst4_pkg.sv
package burst4_pkg;
  parameter int unsigned DEF_BYTE_W    = 9;
  parameter int unsigned DEF_NUM_BYTES = 2;
  parameter int unsigned DEF_ADDR_W    = 8;
  parameter int unsigned DEF_BURST_LEN = 4;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/burst4_seq.sv
// Burst address sequencer. BURST_LEN must be a power of two.
module burst4_seq
  import burst4_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned BURST_LEN = DEF_BURST_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] beat_addr_o
);
  localparam int unsigned BEAT_W = $clog2(BURST_LEN);
  localparam int unsigned BASE_W = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  seq_state_e        state_q;
  logic [BASE_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (cmd_i) begin
            state_q <= SEQ_RUN;
            base_q  <= addr_i[ADDR_W-1:BEAT_W];
            cnt_q   <= '0;
          end
        end
        SEQ_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BEAT) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == SEQ_RUN);
  assign beat_addr_o = {base_q, cnt_q};
endmodule

// File: rtl/burst4_byte_mask.sv
module burst4_byte_mask
  import burst4_pkg::*;
#(
  parameter int unsigned NUM_BYTES = DEF_NUM_BYTES
) (
  input  logic                 beat_en_i,
  input  logic [NUM_BYTES-1:0] ben_ni,
  output logic [NUM_BYTES-1:0] we_o
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_we
    assign we_o[b] = beat_en_i & ~ben_ni[b];
  end
endmodule

// File: rtl/burst4_mem.sv
module burst4_mem
  import burst4_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned BYTE_W    = DEF_BYTE_W,
  parameter int unsigned NUM_BYTES = DEF_NUM_BYTES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BYTES-1:0]        we_i,
  input  logic [ADDR_W-1:0]           waddr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
  input  logic                        re_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_bank
    logic [BYTE_W-1:0] bank_q [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[b]) bank_q[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (re_i) rd_q <= bank_q[raddr_i];
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = rd_q;
  end
endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
  import burst4_pkg::*;
#(
  parameter int unsigned BYTE_W    = DEF_BYTE_W,
  parameter int unsigned NUM_BYTES = DEF_NUM_BYTES,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned BURST_LEN = DEF_BURST_LEN,
  localparam int unsigned DATA_W   = BYTE_W * NUM_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_cmd_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [NUM_BYTES-1:0] wr_ben_ni,
  output logic                 wr_busy_o,
  input  logic                 rd_cmd_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 rd_valid_o,
  output logic                 rd_busy_o
);
  logic                 wr_busy;
  logic [ADDR_W-1:0]    wr_beat_addr;
  logic [NUM_BYTES-1:0] byte_we;
  logic                 rd_busy;
  logic [ADDR_W-1:0]    rd_beat_addr;
  logic                 rd_valid_q;

  burst4_seq #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_wr_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (wr_cmd_i),
    .addr_i      (wr_addr_i),
    .busy_o      (wr_busy),
    .beat_addr_o (wr_beat_addr)
  );

  burst4_byte_mask #(.NUM_BYTES(NUM_BYTES)) u_mask (
    .beat_en_i (wr_busy),
    .ben_ni    (wr_ben_ni),
    .we_o      (byte_we)
  );

  burst4_seq #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_rd_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (rd_cmd_i),
    .addr_i      (rd_addr_i),
    .busy_o      (rd_busy),
    .beat_addr_o (rd_beat_addr)
  );

  burst4_mem #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (byte_we),
    .waddr_i (wr_beat_addr),
    .wdata_i (wr_data_i),
    .re_i    (rd_busy),
    .raddr_i (rd_beat_addr),
    .rdata_o (rd_data_o)
  );

  // Valid tracks the registered read one cycle behind the read sequencer.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else         rd_valid_q <= rd_busy;
  end

  assign wr_busy_o  = wr_busy;
  assign rd_busy_o  = rd_busy;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/burst4_sram_chk.sv
module burst4_sram_chk #(
  parameter int unsigned NUM_BYTES = 2,
  parameter int unsigned BURST_LEN = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_cmd_i,
  input logic                 wr_busy_o,
  input logic                 rd_cmd_i,
  input logic                 rd_busy_o,
  input logic                 rd_valid_o,
  input logic [NUM_BYTES-1:0] byte_we
);
  localparam int unsigned RUN_W = $clog2(BURST_LEN) + 2;
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(BURST_LEN);

  logic [RUN_W-1:0] wr_run_q, rd_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_run_q <= '0;
      rd_run_q <= '0;
    end else begin
      wr_run_q <= wr_busy_o ? wr_run_q + 1'b1 : '0;
      rd_run_q <= rd_busy_o ? rd_run_q + 1'b1 : '0;
    end
  end

  a_r5_wr_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i && !wr_busy_o |=> wr_busy_o);

  a_r5_wr_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_o |-> wr_run_q < RUN_FULL);

  a_r6_wr_run_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_busy_o) |-> wr_run_q == RUN_FULL);

  a_r3_we_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|byte_we) |-> wr_busy_o);

  a_r7_busy_then_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_o |=> rd_valid_o);

  a_r7_valid_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_busy_o));

  a_r8_rd_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_i && !rd_busy_o |=> rd_busy_o);

  a_r8_rd_run_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_busy_o) |-> rd_run_q == RUN_FULL);
endmodule

bind burst4_sram burst4_sram_chk #(
  .NUM_BYTES (NUM_BYTES),
  .BURST_LEN (BURST_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_cmd_i   (wr_cmd_i),
  .wr_busy_o  (wr_busy_o),
  .rd_cmd_i   (rd_cmd_i),
  .rd_busy_o  (rd_busy_o),
  .rd_valid_o (rd_valid_o),
  .byte_we    (byte_we)
);

// File: tb/sim_burst4_sram.sv
module sim_burst4_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] MARK = 18'h2A5A5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_cmd_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = MARK;
  logic [1:0]    wr_ben_ni = 2'b00;
  logic          wr_busy_o;
  logic          rd_cmd_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          rd_valid_o;
  logic          rd_busy_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_q [$];
  logic [AW-1:0] exp_a [$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst4_sram u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_cmd_i(wr_cmd_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_ben_ni(wr_ben_ni), .wr_busy_o(wr_busy_o),
    .rd_cmd_i(rd_cmd_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .rd_busy_o(rd_busy_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write one burst; optionally raise a second command mid-burst (R6).
  task automatic write_burst(input logic [AW-1:0] addr, input logic [3:0][DW-1:0] d,
                             input logic [3:0][1:0] bn, input bit intrude, input logic [AW-1:0] iaddr);
    logic [AW-1:0] base;
    base = {addr[AW-1:2], 2'b00};
    @(negedge clk_i);
    wr_cmd_i = 1'b1; wr_addr_i = addr;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      wr_cmd_i  = intrude && (k == 1);
      wr_addr_i = iaddr;
      wr_data_i = d[k];
      wr_ben_ni = bn[k];
      check(wr_busy_o === 1'b1, "R5 busy during burst", 32'(wr_busy_o), 1);
      for (int b = 0; b < 2; b++)
        if (!bn[k][b]) ref_mem[base + AW'(k)][b*9 +: 9] = d[k][b*9 +: 9];
    end
    @(negedge clk_i);
    wr_cmd_i = 1'b0; wr_ben_ni = 2'b00; wr_data_i = MARK;
    check(wr_busy_o === 1'b0, intrude ? "R6 busy ends after four beats" : "R5 busy ends",
          32'(wr_busy_o), 0);
  endtask

  task automatic read_burst(input logic [AW-1:0] addr, input bit intrude, input logic [AW-1:0] iaddr);
    logic [AW-1:0] base;
    base = {addr[AW-1:2], 2'b00};
    @(negedge clk_i);
    rd_cmd_i = 1'b1; rd_addr_i = addr;
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(ref_mem[base + AW'(k)]);
      exp_a.push_back(base + AW'(k));
    end
    @(negedge clk_i);
    check(rd_busy_o === 1'b1, "R8 read busy", 32'(rd_busy_o), 1);
    rd_cmd_i = intrude; rd_addr_i = iaddr;
    @(negedge clk_i);
    rd_cmd_i = 1'b0;
    while (rd_busy_o) @(negedge clk_i);
  endtask

  // Monitor: pops expected beats as the design presents them (R7).
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected read beat", 32'(rd_data_o), 0);
      end else begin
        logic [DW-1:0] e;
        logic [AW-1:0] a;
        e = exp_q.pop_front();
        a = exp_a.pop_front();
        check(rd_data_o === e, $sformatf("R7 read data at %0h", a), 32'(rd_data_o), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0][DW-1:0] d;
    logic [3:0][1:0]    bn;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    check(wr_busy_o === 1'b0, "R9 wr_busy", 32'(wr_busy_o), 0);
    check(rd_busy_o === 1'b0, "R9 rd_busy", 32'(rd_busy_o), 0);
    check(rd_valid_o === 1'b0, "R9 rd_valid", 32'(rd_valid_o), 0);
    check(rd_data_o === '0, "R9 rd_data", 32'(rd_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rd_valid_o === 1'b0 && wr_busy_o === 1'b0, "R9 idle after reset", 32'(rd_valid_o), 0);

    // R2: fill every location with full-mask bursts
    for (int blk = 0; blk < DEPTH/4; blk++) begin
      for (int k = 0; k < 4; k++) d[k] = DW'($urandom);
      write_burst(AW'(blk*4), d, '0, 1'b0, '0);
    end
    for (int blk = 0; blk < 8; blk++) read_burst(AW'(blk*4), 1'b0, '0);

    // R1: unaligned write and read address fold to block start
    d = {18'h3_0003, 18'h2_0002, 18'h1_0001, 18'h0_0F00};
    write_burst(8'h16, d, '0, 1'b0, '0);
    read_burst(8'h15, 1'b0, '0);
    read_burst(8'h17, 1'b0, '0);

    // R3/R4: per-beat mask pattern low, high, both, high
    d = {18'h1FFFF, 18'h2AAAA, 18'h15555, 18'h3C3C3};
    bn = {2'b01, 2'b00, 2'b01, 2'b10};
    write_burst(8'h40, d, bn, 1'b0, '0);
    read_burst(8'h40, 1'b0, '0);
    // R3: all bytes masked keeps whole block
    write_burst(8'h44, '{default: MARK}, '{default: 2'b11}, 1'b0, '0);
    read_burst(8'h44, 1'b0, '0);

    // R6: second write command mid-burst is dropped; idle data/enables do nothing
    for (int k = 0; k < 4; k++) d[k] = DW'($urandom);
    write_burst(8'h80, d, '0, 1'b1, 8'hC0);
    repeat (6) @(negedge clk_i);
    check(wr_busy_o === 1'b0, "R6 no restart", 32'(wr_busy_o), 0);
    read_burst(8'hC0, 1'b0, '0);
    read_burst(8'h80, 1'b0, '0);

    // R8: second read command mid-burst yields no extra beats
    read_burst(8'h20, 1'b1, 8'h60);
    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R8 beat count", 32'(exp_q.size()), 0);

    // R4: random bursts with random per-beat masks
    for (int n = 0; n < 80; n++) begin
      for (int k = 0; k < 4; k++) begin
        d[k]  = DW'($urandom);
        bn[k] = 2'($urandom);
      end
      write_burst(AW'($urandom), d, bn, 1'b0, '0);
    end
    for (int blk = 0; blk < DEPTH/4; blk++) read_burst(AW'(blk*4 + (blk % 4)), 1'b0, '0);

    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R7 all beats returned", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule